// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a binary up-counter built from identical 4-bit slices. Each slice changes state only on the rising clock edge. It has a synchronous active-low clear, a synchronous active-low parallel preset, and two count enables. One enable is shared by every slice (`en_p`). The other (`en_t`) is passed down the chain as a carry. A slice counts only when both of its enables are high.

A slice's carry output is high when the slice holds all ones and its `en_t` is high. That carry is fed to the `en_t` input of the next slice, so a parameterized number of slices forms one wide synchronous counter.

An optional terminal-count decode shortens the count length. It is enabled by a nonzero modulus parameter. When the count reaches modulus minus one, the decode raises the synchronous clear, so the counter steps through exactly that many states. A chip-level asynchronous active-low reset zeroes the count. Its release is synchronised to the clock inside the block.

Top module: `sync_count_chain`

## Requirements
- R1: The count only changes on a rising clock edge (or on reset). An enable or preset pulse that starts and ends between two edges has no effect on the count.
- R2: With `clr_n` low at a rising edge, the count becomes zero at that edge. This holds whatever the values of `ld_n`, `en_p` and `en_t`.
- R3: With `clr_n` high and `ld_n` low at a rising edge, `din` is copied to `q` at that edge. Any value can be preset, and counting is suspended during the preset.
- R4: With `clr_n`, `ld_n`, `en_p` and `en_t` all high, the count increases by one at each edge. With the modulus disabled, the all-ones value wraps to zero.
- R5: With `clr_n` and `ld_n` high and either enable low, the count holds.
- R6: `carry_out` is high exactly when `q` is all ones and `en_t` is high. `en_p` does not affect it.
- R7: Slice i>0 takes the shared `en_p` and the carry of slice i-1 as its `en_t`. The chain therefore behaves as one binary counter that is STAGES*4 bits wide, with the lowest slice in `q[3:0]`.
- R8: A low `rst_n` zeroes `q` at once, without waiting for a clock edge. The release of `rst_n` takes effect after two rising edges.
- R9: With MOD_N>0, the decode acts when the count equals MOD_N-1, both enables are high and `ld_n` is high. It forces a clear, so the next value is zero and the counter cycles through exactly MOD_N states.
- R10: With MOD_N>0, a preset requested while the count equals MOD_N-1 takes precedence over the decode's clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_n | input | 1 | Synchronous active-low clear |
| ld_n | input | 1 | Synchronous active-low parallel preset |
| en_p | input | 1 | Count enable shared by all slices |
| en_t | input | 1 | Count enable of the lowest slice; also gates the carry |
| din | input | STAGES*4 | Preset data |
| q | output | STAGES*4 | Count value |
| carry_out | output | 1 | Carry of the highest slice |

## Verification
Clear and preset can both be requested in the same cycle while the enables are high. The bench drives all three together and expects zero, then drives preset and count together and expects the preset value. In the modulus instance, the terminal decode and a preset fall on the same edge when a preset is issued with the count at MOD_N-1. The scoreboard expects the preset data there, not zero, and a reference model in the bench predicts every cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int unsigned SLICE_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } slice_op_e;
endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= '0;
    else        sync_r <= {sync_r[0], 1'b1};
  end

  assign rst_sync_n = sync_r[1];
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               ld_n,
  input  logic               en_p,
  input  logic               en_t,
  input  logic [SLICE_W-1:0] d,
  output logic [SLICE_W-1:0] q,
  output logic               carry
);
  slice_op_e          op;
  logic [SLICE_W-1:0] q_r, q_nxt;
  logic               q_en;

  // priority: clear, preset, count, hold
  always_comb begin
    if (!clr_n)            op = OP_CLEAR;
    else if (!ld_n)        op = OP_LOAD;
    else if (en_p && en_t) op = OP_COUNT;
    else                   op = OP_HOLD;
  end

  always_comb begin
    case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = d;
      OP_COUNT: q_nxt = q_r + 1'b1;
      default:  q_nxt = q_r;
    endcase
    q_en = (op != OP_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q     = q_r;
  assign carry = en_t & (&q_r);

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0));
  a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> (q == $past(d)));
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && en_p && en_t) |=> (q == SLICE_W'($past(q) + 1'b1)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/cnt_term_dec.sv
module cnt_term_dec #(
  parameter int unsigned W     = 8,
  parameter int unsigned MOD_N = 0
) (
  input  logic [W-1:0] q,
  input  logic         en_p,
  input  logic         en_t,
  input  logic         ld_n,
  output logic         wrap_clr_n
);
  localparam logic         ACTIVE = (MOD_N > 0);
  localparam logic [W-1:0] LAST_V = (MOD_N > 0) ? W'(MOD_N - 1) : '0;

  logic hit;

  // clear only on an edge that would otherwise count; a preset wins
  assign hit        = (q == LAST_V) & en_p & en_t & ld_n;
  assign wrap_clr_n = ~(ACTIVE & hit);
endmodule

// File: rtl/sync_count_chain.sv
module sync_count_chain
  import cnt_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter int unsigned MOD_N  = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_n,
  input  logic                        ld_n,
  input  logic                        en_p,
  input  logic                        en_t,
  input  logic [STAGES*SLICE_W-1:0]   din,
  output logic [STAGES*SLICE_W-1:0]   q,
  output logic                        carry_out
);
  localparam int unsigned W = STAGES * SLICE_W;
  localparam logic [W-1:0] LAST_V = (MOD_N > 0) ? W'(MOD_N - 1) : '0;

  logic          rst_i_n;
  logic          wrap_clr_n;
  logic          clr_i_n;
  logic [STAGES:0] t_chain;

  cnt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cnt_term_dec #(.W(W), .MOD_N(MOD_N)) u_dec (
    .q          (q),
    .en_p       (en_p),
    .en_t       (en_t),
    .ld_n       (ld_n),
    .wrap_clr_n (wrap_clr_n)
  );

  assign clr_i_n    = clr_n & wrap_clr_n;
  assign t_chain[0] = en_t;

  for (genvar i = 0; i < STAGES; i++) begin : g_slice
    cnt_slice u_slice (
      .clk   (clk),
      .rst_n (rst_i_n),
      .clr_n (clr_i_n),
      .ld_n  (ld_n),
      .en_p  (en_p),
      .en_t  (t_chain[i]),
      .d     (din[i*SLICE_W +: SLICE_W]),
      .q     (q[i*SLICE_W +: SLICE_W]),
      .carry (t_chain[i+1])
    );
  end

  assign carry_out = t_chain[STAGES];

  a_r7_chain_step: assert property (@(posedge clk) disable iff (!rst_i_n)
    (clr_i_n && ld_n && en_p && en_t) |=> (q == W'($past(q) + 1'b1)));
  a_r6_carry_full: assert property (@(posedge clk) disable iff (!rst_i_n)
    carry_out |-> ((&q) && en_t));
  a_r9_mod_wrap: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((MOD_N > 0) && clr_n && ld_n && en_p && en_t && (q == LAST_V)) |=> (q == '0));
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((MOD_N > 0) && clr_n && !ld_n && (q == LAST_V)) |=> (q == $past(din)));
endmodule

// File: tb/sim_sync_count_chain.sv
`timescale 1ns/100ps
module sim_sync_count_chain;
  localparam int MODV = 100;

  logic       clk = 1'b0;
  logic       rst_n, clr_n, ld_n, en_p, en_t;
  logic [7:0] din;
  logic [7:0] q0, q1;
  logic       co0, co1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] m0, m1;
  logic [7:0] e0_q[$];
  logic [7:0] e1_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  sync_count_chain #(.STAGES(2), .MOD_N(0)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p),
    .en_t(en_t), .din(din), .q(q0), .carry_out(co0));

  sync_count_chain #(.STAGES(2), .MOD_N(MODV)) u1 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p),
    .en_t(en_t), .din(din), .q(q1), .carry_out(co1));

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops expected values after the edge they belong to
  always @(negedge clk) begin
    if (e0_q.size() > 0) begin
      logic [7:0] x0, x1;
      string t;
      x0 = e0_q.pop_front();
      x1 = e1_q.pop_front();
      t  = tag_q.pop_front();
      check8({t, " u0"}, q0, x0);
      check8({t, " u1"}, q1, x1);
    end
  end

  // driver: one clock of stimulus, expected result pushed to the scoreboard
  task automatic apply(input logic c, input logic l, input logic ep, input logic et,
                       input logic [7:0] d, input string tag, input bit glitch = 0);
    logic [7:0] n0, n1;
    @(negedge clk);
    #0.5;
    clr_n = c; ld_n = l; en_p = ep; en_t = et; din = d;
    #0.5;
    check8("R1 mid-cycle u0", q0, m0);
    check8("R6 carry u0", {7'd0, co0}, {7'd0, (m0 == 8'hFF) && et});
    check8("R6 carry u1", {7'd0, co1}, {7'd0, (m1 == 8'hFF) && et});
    if (glitch) begin
      // R1: a preset pulse between edges must be ignored
      ld_n = 1'b0; din = ~d;
      #0.3;
      ld_n = l; din = d;
    end
    if (!c) begin n0 = 8'h00; n1 = 8'h00; end
    else if (!l) begin n0 = d; n1 = d; end
    else if (ep && et) begin
      n0 = m0 + 8'd1;
      n1 = (m1 == 8'(MODV - 1)) ? 8'h00 : m1 + 8'd1;
    end else begin n0 = m0; n1 = m1; end
    e0_q.push_back(n0); e1_q.push_back(n1); tag_q.push_back(tag);
    m0 = n0; m1 = n1;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; ld_n = 1'b1; en_p = 1'b0; en_t = 1'b0; din = '0;
    m0 = '0; m1 = '0;
    idle_cycles(3);
    check8("R8 reset u0", q0, 8'h00);
    check8("R8 reset u1", q1, 8'h00);
    rst_n = 1'b1;
    idle_cycles(3);

    apply(1, 1, 0, 1, 8'h00, "R5 hold en_p low");
    apply(1, 0, 0, 0, 8'hA5, "R3 preset");
    apply(1, 1, 1, 1, 8'h00, "R4 count");
    apply(1, 1, 1, 1, 8'h00, "R4 count");
    apply(1, 1, 1, 0, 8'h00, "R5 hold en_t low");
    apply(1, 1, 0, 1, 8'h00, "R5 hold en_p low");
    apply(1, 0, 1, 1, 8'h0E, "R3 preset over count");
    apply(1, 1, 1, 1, 8'h00, "R7 low slice to F");
    apply(1, 1, 1, 1, 8'h00, "R7 carry into upper slice");
    apply(1, 0, 0, 0, 8'hFE, "R3 preset");
    apply(1, 1, 1, 1, 8'h00, "R7 reach all ones");
    apply(1, 1, 0, 1, 8'h00, "R6 en_p low at all ones");
    apply(1, 1, 0, 0, 8'h00, "R6 en_t low at all ones");
    apply(1, 1, 1, 1, 8'h00, "R4 wrap to zero");
    apply(1, 0, 0, 0, 8'h3C, "R3 preset");
    apply(0, 0, 1, 1, 8'h77, "R2 clear beats preset and count");
    apply(1, 0, 1, 1, 8'hC3, "R3 preset");
    apply(0, 1, 0, 0, 8'h00, "R2 clear while idle");

    apply(1, 0, 0, 0, 8'd97, "R3 preset");
    apply(1, 1, 1, 1, 8'h00, "R9 count");
    apply(1, 1, 1, 1, 8'h00, "R9 count to terminal");
    apply(1, 1, 1, 1, 8'h00, "R9 terminal wraps");
    apply(1, 0, 0, 0, 8'd99, "R3 preset terminal");
    apply(1, 1, 0, 1, 8'h00, "R9 no wrap when held");
    apply(1, 0, 1, 1, 8'd50, "R10 preset beats terminal clear");
    apply(0, 1, 0, 0, 8'h00, "R2 clear");
    for (int k = 0; k < 2 * MODV + 3; k++)
      apply(1, 1, 1, 1, 8'h00, "R9 modulus cycle");

    apply(1, 1, 0, 0, 8'h00, "R1 preset glitch ignored", 1);
    apply(1, 1, 1, 1, 8'h00, "R1 count with glitch", 1);

    // R8: asynchronous reset mid-run
    apply(1, 0, 0, 0, 8'h5A, "R3 preset before reset");
    @(negedge clk);
    clr_n = 1'b1; ld_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    #0.5 rst_n = 1'b0;
    #0.5;
    check8("R8 async reset u0", q0, 8'h00);
    check8("R8 async reset u1", q1, 8'h00);
    m0 = '0; m1 = '0;
    idle_cycles(2);
    rst_n = 1'b1;
    // two edges after release the count must still be held in reset
    en_p = 1'b1; en_t = 1'b1;
    @(posedge clk); #0.5;
    check8("R8 release edge 1", q0, 8'h00);
    @(posedge clk); #0.5;
    check8("R8 release edge 2", q0, 8'h00);
    @(posedge clk); #0.5;
    check8("R8 counting after release", q0, 8'h01);
    en_p = 1'b0;
    m0 = 8'h01; m1 = 8'h01;
    apply(1, 1, 1, 1, 8'h00, "R4 count after reset");
    idle_cycles(3);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule